// File: doc/BRIEF.md
# Threshold Write-Protect Controller

This block guards a 64-word by 16-bit non-volatile store with an address threshold. It decodes each loaded serial command from its two-bit opcode, its address field and the levels of the register-select pin (`cmd_pre_i`) and the program-enable pin (`cmd_pe_i`) latched at load time. From these it decides whether a single-word write or a write to every word may go ahead.

The same commands, issued with the register-select pin high, act on a protect-address register instead of the array. A protect-enable command arms the register, and only the command that follows it can then clear, program or permanently lock the register. A cleared flag separates the cleared state from a programmed threshold of all ones, although both hold the same value. The serial shifter, the array and the programming timer sit outside this block. They use the one-cycle grants and the current threshold that this block drives.

Top module: `prot_thresh_ctrl`

## Requirements
- R1: After power-on reset the threshold reads all ones, the register is in the cleared and unlocked state, nothing is armed, and all grant outputs are low.
- R2: A command loaded with opcode 01 and register-select low raises `wr_grant_o` for exactly the cycle after load. It does so only if program-enable is high, `wen_i` is high, and the register is cleared or the address is below the threshold.
- R3: While the register holds a programmed threshold, a single-word write to any address greater than or equal to the threshold is refused.
- R4: Protect-enable is opcode 00 with the top two address bits 11, loaded with register-select high. It arms the register only when `wen_i` and program-enable are both high.
- R5: Clear, protect-write and lock take effect only when the command loaded just before was an accepted protect-enable. Any other command, including a refused protect-enable, removes the arming.
- R6: Protect-write is opcode 01 with register-select and program-enable high. When armed and cleared, it stores the address as the threshold and leaves the cleared state. When the register is not cleared, it is ignored.
- R7: Clear is opcode 11 with an all-ones address. When armed, it stores all ones and enters the cleared state, in which the last address and bulk writes are allowed. A protect-write of all ones blocks both.
- R8: Bulk write is opcode 00 with the top address bits 01 and register-select low. It raises `bulk_grant_o` the cycle after load, only with `wen_i` and program-enable high and the register in the cleared state.
- R9: Lock is opcode 00 with an all-zero address, loaded while armed. After a lock the threshold and cleared state never change again.
- R10: A command loaded with register-select low never changes the protect register.
- R11: Opcode 10 with register-select high raises `prot_rd_o` the cycle after load, whatever the level of `wen_i`.
- R12: At most one of the three grant outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| cmd_valid_i | input | 1 | One-cycle strobe: a command has been loaded |
| cmd_op_i | input | 2 | Opcode of the loaded command |
| cmd_addr_i | input | ADDR_W | Address field of the loaded command |
| cmd_pre_i | input | 1 | Register-select pin level latched at load |
| cmd_pe_i | input | 1 | Program-enable pin level latched at load |
| wen_i | input | 1 | Array write-enable state |
| wr_grant_o | output | 1 | Single-word write granted (one-cycle pulse) |
| bulk_grant_o | output | 1 | Write of every word granted (one-cycle pulse) |
| prot_rd_o | output | 1 | Protect register readback granted (one-cycle pulse) |
| prot_addr_o | output | ADDR_W | Current threshold |

## Verification
Writes are tried below, at and above a programmed threshold, and at the last address in both the cleared state and under an all-ones threshold. These cases separate the threshold comparison from the cleared flag. Protect-write attempts are placed after a refused protect-enable, after an enable broken by an intervening read, and without an earlier clear, so that each prerequisite is shown to be enforced. Clear and write attempts made after a lock, together with register-select-low commands whose bit patterns match protect commands, show that the register is frozen and that the select pin routes each command.

// File: rtl/prot_thresh_pkg.sv
package prot_thresh_pkg;
  typedef enum logic [3:0] {
    K_OTHER,
    K_READ,
    K_WRITE,
    K_WEN,
    K_WDS,
    K_BULK,
    K_PRREAD,
    K_PREN,
    K_PRCLR,
    K_PRWR,
    K_PRLOCK
  } cmd_kind_e;

  localparam logic [1:0] OP_CTRL  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_CLEAR = 2'b11;

  localparam logic [1:0] SUB_DIS  = 2'b00;
  localparam logic [1:0] SUB_BULK = 2'b01;
  localparam logic [1:0] SUB_EN   = 2'b11;
endpackage

// File: rtl/prot_cmd_decode.sv
module prot_cmd_decode
  import prot_thresh_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              pre_i,
  output cmd_kind_e         kind_o
);
  localparam logic [ADDR_W-1:0] ALL_ONES = '1;
  localparam logic [ADDR_W-1:0] ALL_ZERO = '0;

  logic [1:0] sub;
  assign sub = addr_i[ADDR_W-1 -: 2];

  always_comb begin
    kind_o = K_OTHER;
    if (pre_i) begin
      unique case (op_i)
        OP_READ:  kind_o = K_PRREAD;
        OP_WRITE: kind_o = K_PRWR;
        OP_CLEAR: kind_o = (addr_i == ALL_ONES) ? K_PRCLR : K_OTHER;
        default: begin
          if (sub == SUB_EN)          kind_o = K_PREN;
          else if (addr_i == ALL_ZERO) kind_o = K_PRLOCK;
          else                         kind_o = K_OTHER;
        end
      endcase
    end else begin
      unique case (op_i)
        OP_READ:  kind_o = K_READ;
        OP_WRITE: kind_o = K_WRITE;
        OP_CLEAR: kind_o = K_OTHER;
        default: begin
          unique case (sub)
            SUB_EN:   kind_o = K_WEN;
            SUB_DIS:  kind_o = K_WDS;
            SUB_BULK: kind_o = K_BULK;
            default:  kind_o = K_OTHER;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/prot_arm_track.sv
module prot_arm_track
  import prot_thresh_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      valid_i,
  input  cmd_kind_e kind_i,
  input  logic      pe_i,
  input  logic      wen_i,
  output logic      armed_o
);
  logic armed_q;

  // any loaded command consumes or cancels the arming
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_q <= 1'b0;
    else if (valid_i) armed_q <= (kind_i == K_PREN) && pe_i && wen_i;
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/prot_reg.sv
module prot_reg
  import prot_thresh_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  cmd_kind_e         kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              pe_i,
  input  logic              armed_i,
  output logic [ADDR_W-1:0] thresh_o,
  output logic              cleared_o,
  output logic              locked_o
);
  localparam logic [ADDR_W-1:0] ALL_ONES = '1;

  logic [ADDR_W-1:0] thresh_q;
  logic              cleared_q, locked_q;
  logic              alter_ok;

  assign alter_ok = valid_i && armed_i && pe_i && !locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thresh_q  <= ALL_ONES;
      cleared_q <= 1'b1;
      locked_q  <= 1'b0;
    end else if (alter_ok) begin
      unique case (kind_i)
        K_PRCLR: begin
          thresh_q  <= ALL_ONES;
          cleared_q <= 1'b1;
        end
        K_PRWR: begin
          if (cleared_q) begin
            thresh_q  <= addr_i;
            cleared_q <= 1'b0;
          end
        end
        K_PRLOCK: locked_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign thresh_o  = thresh_q;
  assign cleared_o = cleared_q;
  assign locked_o  = locked_q;
endmodule

// File: rtl/prot_grant.sv
module prot_grant
  import prot_thresh_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  cmd_kind_e         kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              pe_i,
  input  logic              wen_i,
  input  logic [ADDR_W-1:0] thresh_i,
  input  logic              cleared_i,
  output logic              wr_o,
  output logic              bulk_o,
  output logic              rd_o
);
  logic wr_d, bulk_d, rd_d, prog_ok;

  assign prog_ok = valid_i && pe_i && wen_i;

  always_comb begin
    wr_d   = prog_ok && (kind_i == K_WRITE) && (cleared_i || (addr_i < thresh_i));
    bulk_d = prog_ok && (kind_i == K_BULK) && cleared_i;
    rd_d   = valid_i && (kind_i == K_PRREAD);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_o   <= 1'b0;
      bulk_o <= 1'b0;
      rd_o   <= 1'b0;
    end else begin
      wr_o   <= wr_d;
      bulk_o <= bulk_d;
      rd_o   <= rd_d;
    end
  end
endmodule

// File: rtl/prot_thresh_ctrl.sv
module prot_thresh_ctrl
  import prot_thresh_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              cmd_pre_i,
  input  logic              cmd_pe_i,
  input  logic              wen_i,
  output logic              wr_grant_o,
  output logic              bulk_grant_o,
  output logic              prot_rd_o,
  output logic [ADDR_W-1:0] prot_addr_o
);
  cmd_kind_e kind;
  logic      armed_q, cleared_q, locked_q;

  prot_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .op_i   (cmd_op_i),
    .addr_i (cmd_addr_i),
    .pre_i  (cmd_pre_i),
    .kind_o (kind)
  );

  prot_arm_track u_arm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (cmd_valid_i),
    .kind_i  (kind),
    .pe_i    (cmd_pe_i),
    .wen_i   (wen_i),
    .armed_o (armed_q)
  );

  prot_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (cmd_valid_i),
    .kind_i    (kind),
    .addr_i    (cmd_addr_i),
    .pe_i      (cmd_pe_i),
    .armed_i   (armed_q),
    .thresh_o  (prot_addr_o),
    .cleared_o (cleared_q),
    .locked_o  (locked_q)
  );

  prot_grant #(.ADDR_W(ADDR_W)) u_gnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (cmd_valid_i),
    .kind_i    (kind),
    .addr_i    (cmd_addr_i),
    .pe_i      (cmd_pe_i),
    .wen_i     (wen_i),
    .thresh_i  (prot_addr_o),
    .cleared_i (cleared_q),
    .wr_o      (wr_grant_o),
    .bulk_o    (bulk_grant_o),
    .rd_o      (prot_rd_o)
  );
endmodule

// File: rtl/prot_thresh_chk.sv
module prot_thresh_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [ADDR_W-1:0] cmd_addr_i,
  input logic              cmd_pre_i,
  input logic              cmd_pe_i,
  input logic              wen_i,
  input logic              wr_grant_o,
  input logic              bulk_grant_o,
  input logic              prot_rd_o,
  input logic [ADDR_W-1:0] prot_addr_o,
  input logic              armed_q,
  input logic              cleared_q,
  input logic              locked_q
);
  a_r2_wr_needs_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_grant_o |-> $past(cmd_valid_i && cmd_pe_i && wen_i && !cmd_pre_i));

  a_r3_wr_below_thresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_grant_o |-> $past(cleared_q || (cmd_addr_i < prot_addr_o)));

  a_r8_bulk_when_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bulk_grant_o |-> $past(cleared_q && wen_i && cmd_pe_i && !cmd_pre_i));

  a_r5_change_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($stable(prot_addr_o) && $stable(cleared_q)) |-> $past(armed_q));

  a_r9_lock_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(locked_q) |-> (locked_q && $stable(prot_addr_o) && $stable(cleared_q)));

  a_r10_pre_low_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!(cmd_valid_i && cmd_pre_i)) |-> ($stable(prot_addr_o) && $stable(cleared_q)));

  a_r11_rd_needs_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_rd_o |-> $past(cmd_valid_i && cmd_pre_i));

  a_r12_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_grant_o, bulk_grant_o, prot_rd_o}));
endmodule

bind prot_thresh_ctrl prot_thresh_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_addr_i   (cmd_addr_i),
  .cmd_pre_i    (cmd_pre_i),
  .cmd_pe_i     (cmd_pe_i),
  .wen_i        (wen_i),
  .wr_grant_o   (wr_grant_o),
  .bulk_grant_o (bulk_grant_o),
  .prot_rd_o    (prot_rd_o),
  .prot_addr_o  (prot_addr_o),
  .armed_q      (armed_q),
  .cleared_q    (cleared_q),
  .locked_q     (locked_q)
);

// File: tb/sim_prot_thresh_ctrl.sv
module sim_prot_thresh_ctrl;
  localparam int AW  = 6;
  localparam int TOP = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic [1:0]    op = '0;
  logic [AW-1:0] addr = '0;
  logic          pre = 1'b0, pe = 1'b0, wen = 1'b0;
  logic          wr_g, bulk_g, rd_g;
  logic [AW-1:0] paddr;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  int m_pa = TOP;
  bit m_clr = 1, m_lock = 0, m_arm = 0;
  bit e_wr = 0, e_bulk = 0, e_rd = 0;

  always #10 clk = ~clk;

  prot_thresh_ctrl #(.ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_op_i(op),
    .cmd_addr_i(addr), .cmd_pre_i(pre), .cmd_pe_i(pe), .wen_i(wen),
    .wr_grant_o(wr_g), .bulk_grant_o(bulk_g), .prot_rd_o(rd_g), .prot_addr_o(paddr)
  );

  task automatic chk1(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk1(tag, "wr_grant", int'(wr_g), int'(e_wr));
    chk1(tag, "bulk_grant", int'(bulk_g), int'(e_bulk));
    chk1(tag, "prot_rd", int'(rd_g), int'(e_rd));
    chk1(tag, "prot_addr", int'(paddr), m_pa);
  endtask

  task automatic cmd(input int o, input int a, input bit p_re, input bit p_e,
                     input bit w_en, input string tag);
    bit nxt_arm;
    int hi;
    @(negedge clk);
    e_wr = 0; e_bulk = 0; e_rd = 0;
    compare({tag, " idle"});
    valid = 1; op = o[1:0]; addr = a[AW-1:0]; pre = p_re; pe = p_e; wen = w_en;
    hi = a >> (AW - 2);
    e_wr   = !p_re && o == 1 && p_e && w_en && (m_clr || a < m_pa);
    e_bulk = !p_re && o == 0 && hi == 1 && p_e && w_en && m_clr;
    e_rd   = p_re && o == 2;
    nxt_arm = 0;
    if (p_re) begin
      if (o == 0 && hi == 3) nxt_arm = w_en && p_e;
      else if (m_arm && p_e && !m_lock) begin
        if (o == 3 && a == TOP) begin m_pa = TOP; m_clr = 1; end
        else if (o == 1 && m_clr) begin m_pa = a; m_clr = 0; end
        else if (o == 0 && a == 0) m_lock = 1;
      end
    end
    m_arm = nxt_arm;
    @(negedge clk);
    valid = 0;
    compare(tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    compare("R1 after reset");

    cmd(1, TOP, 0, 1, 1, "R2 cleared last addr");
    cmd(1, 5, 0, 0, 1, "R2 pe low");
    cmd(1, 5, 0, 1, 0, "R2 wen low");
    cmd(0, 16, 0, 1, 1, "R8 bulk cleared");
    cmd(0, 16, 0, 1, 0, "R8 bulk wen low");

    cmd(0, 48, 1, 1, 0, "R4 enable wen low");
    cmd(1, 10, 1, 1, 1, "R4 write not armed");
    cmd(0, 48, 1, 0, 1, "R4 enable pe low");
    cmd(1, 10, 1, 1, 1, "R4 write not armed pe");
    cmd(0, 48, 1, 1, 1, "R5 enable");
    cmd(2, 3, 0, 0, 1, "R5 read between");
    cmd(1, 10, 1, 1, 1, "R5 arming cancelled");

    cmd(0, 48, 1, 1, 1, "R6 enable");
    cmd(1, 10, 1, 1, 1, "R6 program 10");
    cmd(1, 9, 0, 1, 1, "R3 below");
    cmd(1, 10, 0, 1, 1, "R3 equal");
    cmd(1, 40, 0, 1, 1, "R3 above");
    cmd(0, 16, 0, 1, 1, "R8 bulk programmed");
    cmd(0, 48, 1, 1, 1, "R6 enable again");
    cmd(1, 20, 1, 1, 1, "R6 not cleared");

    cmd(1, 30, 0, 1, 1, "R10 pre low write");
    cmd(3, TOP, 0, 1, 1, "R10 pre low clear pattern");
    cmd(0, 0, 0, 1, 1, "R10 pre low lock pattern");
    cmd(0, 48, 0, 1, 1, "R10 pre low enable");
    cmd(1, 2, 1, 1, 1, "R10 no arm from wen");

    cmd(0, 48, 1, 1, 1, "R7 enable");
    cmd(3, TOP, 1, 1, 1, "R7 clear");
    cmd(1, TOP, 0, 1, 1, "R7 last after clear");
    cmd(0, 16, 0, 1, 1, "R7 bulk after clear");
    cmd(0, 48, 1, 1, 1, "R7 enable");
    cmd(1, TOP, 1, 1, 1, "R7 program all ones");
    cmd(1, TOP, 0, 1, 1, "R7 last blocked");
    cmd(1, TOP - 1, 0, 1, 1, "R7 below all ones");
    cmd(0, 16, 0, 1, 1, "R7 bulk blocked");

    cmd(2, 0, 1, 0, 0, "R11 readback wen low");
    cmd(2, 0, 1, 1, 1, "R11 readback wen high");

    cmd(0, 48, 1, 1, 1, "R9 enable");
    cmd(0, 0, 1, 1, 1, "R9 lock");
    cmd(0, 48, 1, 1, 1, "R9 enable after lock");
    cmd(3, TOP, 1, 1, 1, "R9 clear ignored");
    cmd(0, 48, 1, 1, 1, "R9 enable after lock");
    cmd(1, 4, 1, 1, 1, "R9 write ignored");
    cmd(1, TOP, 0, 1, 1, "R9 last still blocked");
    cmd(0, 16, 0, 1, 1, "R12 bulk still blocked");

    @(negedge clk);
    e_wr = 0; e_bulk = 0; e_rd = 0;
    compare("R12 final idle");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule